// File: doc/BRIEF.md
# Chunked Host-Memory DMA Writer

This block moves fixed-size chunks of card data (4096 bytes by default) from a local FIFO into host memory as bus-master memory-write bursts. A handshake with the host driver paces the transfers. At the start of every cycle the block raises its interrupt bit. The driver then loads a destination address into the address register and clears the interrupt bit through the control register. Only when both steps have happened does the block request the bus and stream the chunk to that address.

The block does not trust a burst to finish. The target or a bridge may abort a burst at any data phase, including before the first data phase completes. The block keeps its own running address and remaining beat count. After each abort it issues a fresh request that starts at the first byte not yet written. When the last beat is accepted, the interrupt bit is raised again, and the next cycle waits for a new address and a new clear. A per-chunk abort counter and a sticky protocol-error flag are available as status pins.

The FIFO read side and the bus data phase are valid/ready streams. The FIFO side offers a beat with `fifo_valid` and holds it until `fifo_ready`. The block drives `fifo_ready` only in its data phase, and only when the bus accepts the beat and no abort is signalled, so the target's back-pressure reaches the FIFO unchanged. A request is held until `req_ready`.

Top module: `dma_chunk_writer`

## Requirements
- R1: After reset is released, `irq` is high from the first clock edge onward. `req_valid` and `proto_err` are low and `abort_count` is zero.
- R2: A transfer starts only when an address has been written (register select 0) and the interrupt bit has been cleared (select 1, data bit 0 = 1), in either order. Neither step alone produces a request.
- R3: A request presents command code 0x7 on `req_cmd`, the running address on `req_addr`, and the beats still to be written on `req_len`. These values stay stable, with `req_valid` high, until `req_ready` is seen.
- R4: In the data phase a beat is accepted in a cycle with `fifo_valid`, `bus_wready` and no `bus_abort`. `bus_wdata` equals `fifo_data`. Each accepted beat advances the address by 8 bytes and lowers the remaining count by one. No FIFO beat is consumed outside the data phase.
- R5: `bus_abort` in the data phase ends the burst without accepting that cycle's beat. The next request resumes at the first untransferred address with the remaining count. This holds even when no beat moved.
- R6: After 512 accepted beats (4096 bytes) `irq` rises. No new request appears until a new address and a new clear arrive.
- R7: `abort_count` counts the aborts of the current chunk. It is cleared when a chunk starts and holds its value after the chunk ends.
- R8: An address write while a transfer is in progress is ignored and sets `proto_err`. The flag stays set until a control write with data bit 1 = 1.
- R9: The low three bits of a written address are dropped, so bursts are always 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 = destination address, 1 = control |
| reg_wr_data | input | 32 | Write data; control bit 0 clears the interrupt, bit 1 clears the error flag |
| irq | output | 1 | Interrupt bit |
| abort_count | output | 8 | Aborts seen in the current chunk |
| proto_err | output | 1 | Sticky flag: address written during a transfer |
| fifo_valid | input | 1 | FIFO offers a beat |
| fifo_ready | output | 1 | Beat taken from the FIFO |
| fifo_data | input | 64 | FIFO beat |
| req_valid | output | 1 | Burst request |
| req_ready | input | 1 | Request accepted |
| req_cmd | output | 4 | Bus command (memory write) |
| req_addr | output | 32 | Burst start address |
| req_len | output | 10 | Beats left in the chunk |
| bus_wvalid | output | 1 | Data phase beat valid |
| bus_wready | input | 1 | Target accepts the beat |
| bus_wdata | output | 64 | Data phase beat |
| bus_abort | input | 1 | Target or bridge aborts the burst |

## Verification
Two chunks run against a target model with periodic `req_ready` stalls, periodic `bus_wready` stalls and FIFO gaps, so that each kind of back-pressure is seen both on its own and together with the others. Each chunk follows an abort plan. Aborts before any data phase, and several in a row, show whether the block advances its address when it must not. Aborts deep into a burst show whether the resume point is exactly the next beat. The two chunks present the driver's handshake in opposite orders, which tells whether the block truly needs both steps. An address write in the middle of a burst shows whether the running stream can be disturbed.

// File: rtl/dma_chunk_pkg.sv
package dma_chunk_pkg;
  typedef enum logic [1:0] {
    ST_ARM,
    ST_WAIT,
    ST_REQ,
    ST_DATA
  } dma_state_e;

  localparam logic [3:0] CMD_MEM_WRITE = 4'h7;
  localparam logic SEL_ADDR = 1'b0;
  localparam logic SEL_CTRL = 1'b1;
endpackage

// File: rtl/dma_host_regs.sv
module dma_host_regs #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_wr_sel,
  input  logic [ADDR_W-1:0] reg_wr_data,
  input  logic              busy,
  input  logic              set_irq,
  input  logic              consume,
  output logic [ADDR_W-1:0] dest_addr,
  output logic              addr_valid,
  output logic              irq_bit,
  output logic              proto_err
);
  import dma_chunk_pkg::*;

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BEAT_BYTES - 1);

  logic wr_addr, wr_ctrl;
  assign wr_addr = reg_wr_en && (reg_wr_sel == SEL_ADDR);
  assign wr_ctrl = reg_wr_en && (reg_wr_sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_addr  <= '0;
      addr_valid <= 1'b0;
      irq_bit    <= 1'b0;
      proto_err  <= 1'b0;
    end else begin
      if (wr_addr) begin
        if (busy) begin
          proto_err <= 1'b1;
        end else begin
          dest_addr  <= reg_wr_data & ALIGN_MASK;
          addr_valid <= 1'b1;
        end
      end else if (consume) begin
        addr_valid <= 1'b0;
      end
      if (wr_ctrl && reg_wr_data[1]) proto_err <= 1'b0;
      if (set_irq) irq_bit <= 1'b1;
      else if (wr_ctrl && reg_wr_data[0] && !busy) irq_bit <= 1'b0;
    end
  end

  AST_ADDR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr && busy |=> proto_err && $stable(dest_addr)); // R8
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr && !busy |=> (dest_addr & ~ALIGN_MASK) == '0); // R9
endmodule

// File: rtl/dma_progress.sv
module dma_progress #(
  parameter int ADDR_W     = 32,
  parameter int BEATS      = 512,
  parameter int BEAT_BYTES = 8,
  parameter int ABORT_W    = 8,
  localparam int LEN_W     = $clog2(BEATS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ADDR_W-1:0]  base,
  input  logic               beat,
  input  logic               abort_evt,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [LEN_W-1:0]   remaining,
  output logic [ABORT_W-1:0] abort_count,
  output logic               last_beat
);
  localparam logic [ADDR_W-1:0]  STEP      = ADDR_W'(BEAT_BYTES);
  localparam logic [LEN_W-1:0]   FULL      = LEN_W'(BEATS);
  localparam logic [ABORT_W-1:0] ABORT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr    <= '0;
      remaining   <= '0;
      abort_count <= '0;
    end else if (load) begin
      cur_addr    <= base;
      remaining   <= FULL;
      abort_count <= '0;
    end else begin
      if (beat) begin
        cur_addr  <= cur_addr + STEP;
        remaining <= remaining - 1'b1;
      end
      if (abort_evt && abort_count != ABORT_MAX) abort_count <= abort_count + 1'b1;
    end
  end

  assign last_beat = (remaining == LEN_W'(1));

  AST_ABORT_HOLDS_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> $stable(cur_addr) && $stable(remaining)); // R5
  AST_NO_BEAT_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> remaining != '0); // R6
endmodule

// File: rtl/dma_burst_fsm.sv
module dma_burst_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_valid,
  input  logic irq_bit,
  input  logic req_ready,
  input  logic fifo_valid,
  input  logic bus_wready,
  input  logic bus_abort,
  input  logic last_beat,
  output logic busy,
  output logic set_irq,
  output logic start,
  output logic beat,
  output logic abort_evt,
  output logic req_valid,
  output logic bus_wvalid,
  output logic fifo_ready
);
  import dma_chunk_pkg::*;

  dma_state_e state, state_nx;

  always_comb begin
    state_nx  = state;
    set_irq   = 1'b0;
    start     = 1'b0;
    beat      = 1'b0;
    abort_evt = 1'b0;
    unique case (state)
      ST_ARM: begin
        set_irq  = 1'b1;
        state_nx = ST_WAIT;
      end
      ST_WAIT: begin
        if (addr_valid && !irq_bit) begin
          start    = 1'b1;
          state_nx = ST_REQ;
        end
      end
      ST_REQ: begin
        if (req_ready) state_nx = ST_DATA;
      end
      ST_DATA: begin
        if (bus_abort) begin
          abort_evt = 1'b1;
          state_nx  = ST_REQ;
        end else if (fifo_valid && bus_wready) begin
          beat = 1'b1;
          if (last_beat) begin
            set_irq  = 1'b1;
            state_nx = ST_WAIT;
          end
        end
      end
      default: state_nx = ST_ARM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_ARM;
    else        state <= state_nx;
  end

  assign busy       = (state == ST_REQ) || (state == ST_DATA);
  assign req_valid  = (state == ST_REQ);
  assign bus_wvalid = (state == ST_DATA) && fifo_valid;
  assign fifo_ready = (state == ST_DATA) && bus_wready && !bus_abort;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid); // R3
  AST_ABORT_REREQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> req_valid); // R5
endmodule

// File: rtl/dma_chunk_writer.sv
module dma_chunk_writer #(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_BYTES = 4096,
  parameter int BEAT_BYTES  = 8,
  parameter int ABORT_W     = 8,
  localparam int BEATS      = CHUNK_BYTES / BEAT_BYTES,
  localparam int LEN_W      = $clog2(BEATS + 1),
  localparam int DATA_W     = BEAT_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic               reg_wr_sel,
  input  logic [ADDR_W-1:0]  reg_wr_data,
  output logic               irq,
  output logic [ABORT_W-1:0] abort_count,
  output logic               proto_err,
  input  logic               fifo_valid,
  output logic               fifo_ready,
  input  logic [DATA_W-1:0]  fifo_data,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [3:0]         req_cmd,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [LEN_W-1:0]   req_len,
  output logic               bus_wvalid,
  input  logic               bus_wready,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_abort
);
  import dma_chunk_pkg::*;

  logic              busy, set_irq, start, beat, abort_evt, last_beat;
  logic              addr_valid, irq_bit;
  logic [ADDR_W-1:0] dest_addr, cur_addr;
  logic [LEN_W-1:0]  remaining;

  dma_host_regs #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .busy(busy), .set_irq(set_irq), .consume(start),
    .dest_addr(dest_addr), .addr_valid(addr_valid), .irq_bit(irq_bit),
    .proto_err(proto_err)
  );

  dma_progress #(.ADDR_W(ADDR_W), .BEATS(BEATS), .BEAT_BYTES(BEAT_BYTES),
                 .ABORT_W(ABORT_W)) u_prog (
    .clk(clk), .rst_n(rst_n),
    .load(start), .base(dest_addr), .beat(beat), .abort_evt(abort_evt),
    .cur_addr(cur_addr), .remaining(remaining), .abort_count(abort_count),
    .last_beat(last_beat)
  );

  dma_burst_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .addr_valid(addr_valid), .irq_bit(irq_bit), .req_ready(req_ready),
    .fifo_valid(fifo_valid), .bus_wready(bus_wready), .bus_abort(bus_abort),
    .last_beat(last_beat),
    .busy(busy), .set_irq(set_irq), .start(start), .beat(beat),
    .abort_evt(abort_evt), .req_valid(req_valid), .bus_wvalid(bus_wvalid),
    .fifo_ready(fifo_ready)
  );

  assign irq       = irq_bit;
  assign req_cmd   = CMD_MEM_WRITE;
  assign req_addr  = cur_addr;
  assign req_len   = remaining;
  assign bus_wdata = fifo_data;

  AST_START_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(addr_valid) && !$past(irq_bit)); // R2
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    beat && remaining == LEN_W'(1) |=> irq && !busy); // R6
  AST_ADDR_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cur_addr == dest_addr + ADDR_W'((BEATS - int'(remaining)) * BEAT_BYTES)); // R4
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(req_addr) && $stable(req_len)); // R3
endmodule

// File: tb/dma_chunk_writer_test.sv
module dma_chunk_writer_test;
  localparam int BEATS = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_wr_sel = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic        irq, proto_err;
  logic [7:0]  abort_count;
  logic        fifo_valid = 1'b0;
  logic        fifo_ready;
  logic [63:0] fifo_data = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [3:0]  req_cmd;
  logic [31:0] req_addr;
  logic [9:0]  req_len;
  logic        bus_wvalid;
  logic        bus_wready = 1'b0;
  logic [63:0] bus_wdata;
  logic        bus_abort = 1'b0;

  dma_chunk_writer uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .irq(irq), .abort_count(abort_count), .proto_err(proto_err),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_data(fifo_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len),
    .bus_wvalid(bus_wvalid), .bus_wready(bus_wready), .bus_wdata(bus_wdata),
    .bus_abort(bus_abort)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] exp_addr_q[$];
  logic [63:0] exp_data_q[$];
  int plan[4];
  int burst_idx = 0;
  int burst_beats = 0;
  int chunk_aborts = 0;
  int fifo_idx = 0;
  int cyc = 0;
  bit in_data = 1'b0;
  bit pend = 1'b0;
  logic [31:0] pend_addr = '0;
  logic [31:0] track_addr = '0;

  function automatic logic [63:0] beat_word(int k);
    return {32'(k) ^ 32'hA5A5_0000, 32'(k * 3 + 1)};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_chunk(logic [31:0] base, int p0, int p1, int p2, int p3);
    plan[0] = p0; plan[1] = p1; plan[2] = p2; plan[3] = p3;
    burst_idx = 0;
    chunk_aborts = 0;
    for (int i = 0; i < BEATS; i++) begin
      exp_addr_q.push_back(base + 32'(i * 8));
      exp_data_q.push_back(beat_word(fifo_idx + i));
    end
  endtask

  task automatic reg_write(logic sel, logic [31:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_done();
    while (!irq) @(negedge clk);
  endtask

  // bus target, FIFO source and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      req_ready  = (cyc % 3 == 0);
      bus_wready = (cyc % 7 != 3);
      fifo_valid = (cyc % 5 != 1);
      fifo_data  = beat_word(fifo_idx);
      bus_abort  = in_data && burst_idx < 4 && plan[burst_idx] >= 0 &&
                   burst_beats == plan[burst_idx];
      #1;
      if (pend) begin
        check(req_valid == 1'b1, "R3", "request dropped before accept", 64'(req_valid), 64'd1);
        check(req_addr == pend_addr, "R3", "request address moved", 64'(req_addr), 64'(pend_addr));
      end
      pend = 1'b0;
      if (!in_data)
        check(fifo_ready == 1'b0, "R4", "FIFO read outside data phase", 64'(fifo_ready), 64'd0);
      if (bus_wvalid)
        check(bus_wdata == fifo_data, "R4", "bus data differs from FIFO", bus_wdata, fifo_data);
      if (req_valid && req_ready) begin
        check(req_cmd == 4'h7, "R3", "command code", 64'(req_cmd), 64'h7);
        check(32'(req_len) == 32'(exp_addr_q.size()), "R5", "request length",
              64'(req_len), 64'(exp_addr_q.size()));
        if (exp_addr_q.size() > 0)
          check(req_addr == exp_addr_q[0], "R5", "resume address", 64'(req_addr), 64'(exp_addr_q[0]));
        track_addr  = req_addr;
        in_data     = 1'b1;
        burst_beats = 0;
      end else if (req_valid) begin
        pend      = 1'b1;
        pend_addr = req_addr;
      end else if (in_data && bus_abort) begin
        chunk_aborts++;
        burst_idx++;
        in_data = 1'b0;
      end else if (fifo_valid && fifo_ready) begin
        if (exp_addr_q.size() == 0) begin
          check(1'b0, "R6", "beat beyond chunk end", 64'(track_addr), 64'd0);
        end else begin
          logic [31:0] ea;
          logic [63:0] ed;
          ea = exp_addr_q.pop_front();
          ed = exp_data_q.pop_front();
          check(track_addr == ea, "R4", "beat address", 64'(track_addr), 64'(ea));
          check(bus_wdata == ed, "R4", "beat data", bus_wdata, ed);
        end
        fifo_idx++;
        track_addr = track_addr + 32'd8;
        burst_beats++;
        if (exp_addr_q.size() == 0) in_data = 1'b0;
      end
    end
  end

  initial begin
    plan = '{-1, -1, -1, -1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R1", "irq after reset", 64'(irq), 64'd1);
    check(req_valid == 1'b0, "R1", "no request after reset", 64'(req_valid), 64'd0);
    check(abort_count == 8'd0, "R1", "abort count after reset", 64'(abort_count), 64'd0);
    check(proto_err == 1'b0, "R1", "error flag after reset", 64'(proto_err), 64'd0);

    // chunk 1: clear first, address second; aborts at 0 and deep in bursts
    reg_write(1'b1, 32'h1);
    repeat (6) @(negedge clk);
    check(irq == 1'b0, "R2", "irq cleared", 64'(irq), 64'd0);
    check(req_valid == 1'b0, "R2", "clear alone must not start", 64'(req_valid), 64'd0);
    load_chunk(32'h1000_0000, 0, 100, 0, 37);
    reg_write(1'b0, 32'h1000_0005); // R9: low bits dropped
    while (fifo_idx < 150) @(negedge clk);
    reg_write(1'b0, 32'h3000_0000);
    wait_done();
    check(exp_addr_q.size() == 0, "R6", "beats left at irq", 64'(exp_addr_q.size()), 64'd0);
    check(abort_count == 8'(chunk_aborts), "R7", "abort count chunk 1",
          64'(abort_count), 64'(chunk_aborts));
    check(chunk_aborts == 4, "R5", "planned aborts delivered", 64'(chunk_aborts), 64'd4);
    check(proto_err == 1'b1, "R8", "error flag after write in transfer", 64'(proto_err), 64'd1);
    repeat (8) @(negedge clk);
    check(req_valid == 1'b0, "R6", "no restart without handshake", 64'(req_valid), 64'd0);
    reg_write(1'b1, 32'h2);
    @(negedge clk);
    check(proto_err == 1'b0, "R8", "error flag cleared", 64'(proto_err), 64'd0);
    check(irq == 1'b1, "R6", "irq kept by error clear", 64'(irq), 64'd1);

    // chunk 2: address first, clear second; back-to-back zero-beat aborts
    load_chunk(32'h2000_0800, 0, 0, 200, -1);
    reg_write(1'b0, 32'h2000_0800);
    repeat (5) @(negedge clk);
    check(req_valid == 1'b0, "R2", "address alone must not start", 64'(req_valid), 64'd0);
    check(irq == 1'b1, "R2", "irq still set", 64'(irq), 64'd1);
    reg_write(1'b1, 32'h1);
    repeat (3) @(negedge clk);
    check(abort_count <= 8'd2, "R7", "count restarted for new chunk", 64'(abort_count), 64'd2);
    wait_done();
    check(exp_addr_q.size() == 0, "R6", "beats left at irq", 64'(exp_addr_q.size()), 64'd0);
    check(abort_count == 8'd3, "R7", "abort count chunk 2", 64'(abort_count), 64'd3);
    check(proto_err == 1'b0, "R8", "no error without stray write", 64'(proto_err), 64'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule